// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block takes four maskable interrupt request lines and latches each one as pending. It chooses among them by fixed priority, gated by a single global enable bit. When the enable bit is set and at least one request is pending, the block waits for the core to signal an instruction boundary. It then runs a fixed entry sequence:

1. Push the return address onto the stack, low byte first, through a request/acknowledge handshake.
2. Present the 2-bit code of the winning source for two vector-fetch cycles.
3. Signal entry-complete and drop the global enable bit.

A return-from-interrupt strobe sets the enable bit again. With the acknowledge held high, an entry lasts exactly five cycles.

The core drives the instruction-boundary, return-from-interrupt and enable-write strobes. It answers the stack requests and uses the vector code to form the handler address.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, the block is idle and all outputs are low. This covers `pendOut`, `gieOut`, `entryBusy`, `stackReq`, `stackHi`, `vecFetch`, `entryDone` and `vecSel`.
- R2: A high `irqReq[i]` at a clock edge sets `pendOut[i]` from the next cycle on. The bit stays set after the request drops, and it stays set while `gieOut` is 0 even across instruction boundaries.
- R3: A software write (`gieWrEn`) loads `gieWrData` into `gieOut`. Apart from return-from-interrupt, nothing else can set `gieOut`.
- R4: An entry starts at a clock edge only when `instrDone`, `gieOut` and at least one pending bit are all high at that edge. `entryBusy` rises in the next cycle.
- R5: At entry start, `vecSel` takes the index of the highest pending bit. The codes are: 3 for the edge/wake-up source, 2 for timer 0, 1 for timer 1 and 0 for the software source. `vecSel` holds that value through the whole entry.
- R6: The stack push uses `stackReq`. The low byte goes first (`stackHi`=0), then the high byte (`stackHi`=1). Each byte request holds until `stackAck` is sampled high.
- R7: With `stackAck` held high, the entry takes five cycles:
  - two stack cycles;
  - two cycles with `vecFetch`=1;
  - one cycle with `entryDone`=1.
  
  The block is idle again in the sixth cycle.
- R8: `gieOut` is 0 in the cycle after the `entryDone` cycle.
- R9: At entry start, only the winner's pending bit clears. Other pending bits remain set. A request that arrives during the entry is held pending, even if it has higher priority.
- R10: `retiStrobe` sets `gieOut` to 1. It overrides a software write in the same cycle. The clear at the end of an entry overrides both.
- R11: A high `pendClr[i]` clears `pendOut[i]`. If `irqReq[i]` is high in the same cycle, the bit stays set.
- R12: If the winning source requests again at the edge where its entry starts, its pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | 4 | Request lines; bit 3 has the highest priority, bit 0 the lowest |
| pendClr | input | 4 | Software clear of pending bits |
| instrDone | input | 1 | Instruction-boundary strobe |
| retiStrobe | input | 1 | Return-from-interrupt strobe |
| gieWrEn | input | 1 | Software write strobe for the global enable |
| gieWrData | input | 1 | Value written to the global enable |
| stackAck | input | 1 | Stack byte accepted |
| stackReq | output | 1 | Request to push one return-address byte |
| stackHi | output | 1 | 0 for the low byte, 1 for the high byte |
| vecFetch | output | 1 | Vector fetch cycle |
| vecSel | output | 2 | Code of the winning source |
| entryDone | output | 1 | Last cycle of the entry |
| entryBusy | output | 1 | Entry sequence in progress |
| gieOut | output | 1 | Global interrupt enable |
| pendOut | output | 4 | Pending bits |

## Verification
Two pairs of events can land in the same cycle:
- A new request can arrive on the very line whose pending bit is being cleared, either by entry start or by software clear. The bench drives a request on the winner's line at the start edge, and a request together with a clear on one bit. It expects the bit to remain pending.
- A return-from-interrupt can coincide with another write to the enable bit. The bench pairs it with a software write of 0, where the return must win. It also drives the return during the final entry cycle, where the entry-end clear must win.

A behavioural model is compared against every output on every clock.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_LO = 3'd1,
    ST_PUSH_HI = 3'd2,
    ST_VEC_LO  = 3'd3,
    ST_VEC_HI  = 3'd4,
    ST_DONE    = 3'd5
  } entryState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startEntry;  // latch winner, clear its pending bit
    logic clearGie;    // final cycle of entry
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 4,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req,
  output logic [IDX_W-1:0]   winIdx,
  output logic               anyReq
);
  // ascending scan: last set bit (highest index) wins
  always_comb begin
    winIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i]) winIdx = IDX_W'(i);
    end
    anyReq = |req;
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrDone,
  input  logic        gieOn,
  input  logic        anyPend,
  input  logic        stackAck,
  output ctrlStrobe_t strobes,
  output logic        stackReq,
  output logic        stackHi,
  output logic        vecFetch,
  output logic        entryDone,
  output logic        entryBusy
);
  entryState_t state, stateNext;
  logic takeNow;

  assign takeNow = (state == ST_IDLE) && instrDone && gieOn && anyPend;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:    if (takeNow) stateNext = ST_PUSH_LO;
      ST_PUSH_LO: if (stackAck) stateNext = ST_PUSH_HI;
      ST_PUSH_HI: if (stackAck) stateNext = ST_VEC_LO;
      ST_VEC_LO:  stateNext = ST_VEC_HI;
      ST_VEC_HI:  stateNext = ST_DONE;
      ST_DONE:    stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.startEntry = takeNow;
    strobes.clearGie   = (state == ST_DONE);
  end

  assign stackReq  = (state == ST_PUSH_LO) || (state == ST_PUSH_HI);
  assign stackHi   = (state == ST_PUSH_HI);
  assign vecFetch  = (state == ST_VEC_LO) || (state == ST_VEC_HI);
  assign entryDone = (state == ST_DONE);
  assign entryBusy = (state != ST_IDLE);
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic [NUM_SRC-1:0] pendClr,
  input  logic               retiStrobe,
  input  logic               gieWrEn,
  input  logic               gieWrData,
  input  ctrlStrobe_t        strobes,
  output logic [NUM_SRC-1:0] pendOut,
  output logic               anyPend,
  output logic               gieOut,
  output logic [IDX_W-1:0]   vecSel
);
  logic [IDX_W-1:0]   winIdx;
  logic [NUM_SRC-1:0] grantMask;

  irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
    .req    (pendOut),
    .winIdx (winIdx),
    .anyReq (anyPend)
  );

  assign grantMask = strobes.startEntry
                     ? ({{(NUM_SRC-1){1'b0}}, 1'b1} << winIdx)
                     : '0;

  // one pending latch per source; a new request beats any clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          pendOut[i] <= 1'b0;
      else if (irqReq[i]) pendOut[i] <= 1'b1;
      else if (pendClr[i] || grantMask[i]) pendOut[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 gieOut <= 1'b0;
    else if (strobes.clearGie) gieOut <= 1'b0;
    else if (retiStrobe)       gieOut <= 1'b1;
    else if (gieWrEn)          gieOut <= gieWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   vecSel <= '0;
    else if (strobes.startEntry) vecSel <= winIdx;
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic [NUM_SRC-1:0] pendClr,
  input  logic               instrDone,
  input  logic               retiStrobe,
  input  logic               gieWrEn,
  input  logic               gieWrData,
  input  logic               stackAck,
  output logic               stackReq,
  output logic               stackHi,
  output logic               vecFetch,
  output logic [IDX_W-1:0]   vecSel,
  output logic               entryDone,
  output logic               entryBusy,
  output logic               gieOut,
  output logic [NUM_SRC-1:0] pendOut
);
  ctrlStrobe_t strobes;
  logic anyPend;

  irq_entry_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrDone (instrDone),
    .gieOn     (gieOut),
    .anyPend   (anyPend),
    .stackAck  (stackAck),
    .strobes   (strobes),
    .stackReq  (stackReq),
    .stackHi   (stackHi),
    .vecFetch  (vecFetch),
    .entryDone (entryDone),
    .entryBusy (entryBusy)
  );

  irq_entry_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .irqReq     (irqReq),
    .pendClr    (pendClr),
    .retiStrobe (retiStrobe),
    .gieWrEn    (gieWrEn),
    .gieWrData  (gieWrData),
    .strobes    (strobes),
    .pendOut    (pendOut),
    .anyPend    (anyPend),
    .gieOut     (gieOut),
    .vecSel     (vecSel)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int NUM_SRC = 4,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqReq,
  input logic               instrDone,
  input logic               retiStrobe,
  input logic               gieWrEn,
  input logic               gieWrData,
  input logic               stackAck,
  input logic               stackReq,
  input logic               stackHi,
  input logic               vecFetch,
  input logic [IDX_W-1:0]   vecSel,
  input logic               entryDone,
  input logic               entryBusy,
  input logic               gieOut,
  input logic [NUM_SRC-1:0] pendOut
);
  p_req_latched_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|irqReq) |=> ((pendOut & $past(irqReq)) == $past(irqReq)));

  p_gie_set_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gieOut) |-> $past(retiStrobe || (gieWrEn && gieWrData)));

  p_start_at_boundary_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(entryBusy) |-> $past(instrDone && gieOut && (|pendOut)));

  p_vec_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    (entryBusy && !$rose(entryBusy)) |-> $stable(vecSel));

  p_stack_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stackReq && !stackAck) |=> (stackReq && $stable(stackHi)));

  p_phase_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stackReq, vecFetch, entryDone}));

  p_done_then_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |=> !entryBusy);

  p_gie_off_after_r8: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |=> !gieOut);

  p_reti_sets_r10: assert property (@(posedge clk) disable iff (!rstN)
    (retiStrobe && !entryDone) |=> gieOut);
endmodule

bind irq_entry_seq irq_entry_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .irqReq     (irqReq),
  .instrDone  (instrDone),
  .retiStrobe (retiStrobe),
  .gieWrEn    (gieWrEn),
  .gieWrData  (gieWrData),
  .stackAck   (stackAck),
  .stackReq   (stackReq),
  .stackHi    (stackHi),
  .vecFetch   (vecFetch),
  .vecSel     (vecSel),
  .entryDone  (entryDone),
  .entryBusy  (entryBusy),
  .gieOut     (gieOut),
  .pendOut    (pendOut)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN;
  logic [3:0] irqReq, pendClr;
  logic       instrDone, retiStrobe, gieWrEn, gieWrData, stackAck;
  logic       stackReq, stackHi, vecFetch, entryDone, entryBusy, gieOut;
  logic [1:0] vecSel;
  logic [3:0] pendOut;

  irq_entry_seq u0 (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .pendClr(pendClr),
    .instrDone(instrDone), .retiStrobe(retiStrobe), .gieWrEn(gieWrEn),
    .gieWrData(gieWrData), .stackAck(stackAck), .stackReq(stackReq),
    .stackHi(stackHi), .vecFetch(vecFetch), .vecSel(vecSel),
    .entryDone(entryDone), .entryBusy(entryBusy), .gieOut(gieOut),
    .pendOut(pendOut)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference: step number 0 (idle) .. 5 (done)
  int         mStep;
  logic [3:0] mPend;
  logic       mGie;
  int         mVec;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelUpdate();
    bit start;
    int win;
    logic [3:0] nPend;
    win = 0;
    for (int i = 0; i < 4; i++) if (mPend[i]) win = i;
    start = (mStep == 0) && instrDone && mGie && (mPend != 0);
    nPend = mPend;
    for (int i = 0; i < 4; i++) begin
      if (irqReq[i]) nPend[i] = 1'b1;
      else if (pendClr[i] || (start && win == i)) nPend[i] = 1'b0;
    end
    if (mStep == 5)   mGie = 1'b0;
    else if (retiStrobe) mGie = 1'b1;
    else if (gieWrEn) mGie = gieWrData;
    if (start) mVec = win;
    case (mStep)
      0: if (start) mStep = 1;
      1: if (stackAck) mStep = 2;
      2: if (stackAck) mStep = 3;
      5: mStep = 0;
      default: mStep = mStep + 1;
    endcase
    mPend = nPend;
  endtask

  task automatic compareAll();
    chk("R9 pendOut vs model", int'(pendOut), int'(mPend));
    chk("R3 gieOut vs model", int'(gieOut), int'(mGie));
    chk("R6 stackReq vs model", int'(stackReq), int'(mStep == 1 || mStep == 2));
    chk("R6 stackHi vs model", int'(stackHi), int'(mStep == 2));
    chk("R7 vecFetch vs model", int'(vecFetch), int'(mStep == 3 || mStep == 4));
    chk("R7 entryDone vs model", int'(entryDone), int'(mStep == 5));
    chk("R4 entryBusy vs model", int'(entryBusy), int'(mStep != 0));
    chk("R5 vecSel vs model", int'(vecSel), mVec);
  endtask

  task automatic cyc(logic [3:0] irq, logic [3:0] clr, logic idone,
                     logic reti, logic wen, logic wdat);
    irqReq = irq; pendClr = clr; instrDone = idone;
    retiStrobe = reti; gieWrEn = wen; gieWrData = wdat;
    @(posedge clk);
    modelUpdate();
    #2;
    compareAll();
    irqReq = '0; pendClr = '0; instrDone = 0;
    retiStrobe = 0; gieWrEn = 0; gieWrData = 0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; irqReq = '0; pendClr = '0; instrDone = 0;
    retiStrobe = 0; gieWrEn = 0; gieWrData = 0; stackAck = 1;
    mStep = 0; mPend = '0; mGie = 0; mVec = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 pendOut", int'(pendOut), 0);
    chk("R1 gieOut", int'(gieOut), 0);
    chk("R1 entryBusy", int'(entryBusy), 0);
    chk("R1 stackReq", int'(stackReq), 0);
    chk("R1 entryDone", int'(entryDone), 0);
    chk("R1 vecSel", int'(vecSel), 0);
    @(negedge clk);

    // R2: pending while disabled
    cyc(4'b0001, 0, 0, 0, 0, 0);
    chk("R2 pend set", int'(pendOut), 1);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R2 pend held while disabled", int'(pendOut), 1);
    chk("R4 no entry while disabled", int'(entryBusy), 0);

    // R3: software enable
    cyc(0, 0, 0, 0, 1, 1);
    chk("R3 write sets gie", int'(gieOut), 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R4 no entry without boundary", int'(entryBusy), 0);

    // entry on the software source
    cyc(0, 0, 1, 0, 0, 0);
    chk("R4 entry started", int'(entryBusy), 1);
    chk("R5 software code", int'(vecSel), 0);
    chk("R9 winner cleared", int'(pendOut), 0);
    chk("R6 low byte first", int'(stackHi), 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R6 high byte second", int'(stackHi), 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R7 vector fetch 1", int'(vecFetch), 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R7 vector fetch 2", int'(vecFetch), 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R7 done in fifth cycle", int'(entryDone), 1);
    chk("R8 gie still on in done", int'(gieOut), 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R7 idle in sixth cycle", int'(entryBusy), 0);
    chk("R8 gie cleared", int'(gieOut), 0);

    // R10 RETI
    cyc(0, 0, 0, 1, 0, 0);
    chk("R10 reti sets gie", int'(gieOut), 1);

    // priority with two pending, ack stalled, late higher request
    cyc(4'b0110, 0, 0, 0, 0, 0);
    stackAck = 0;
    cyc(0, 0, 1, 0, 0, 0);
    chk("R5 timer0 code", int'(vecSel), 2);
    chk("R9 loser stays pending", int'(pendOut), 4'b0010);
    cyc(4'b1000, 0, 0, 0, 0, 0);
    chk("R6 stall holds request", int'(stackReq), 1);
    chk("R6 stall stays low byte", int'(stackHi), 0);
    chk("R9 late high request pending", int'(pendOut), 4'b1010);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R6 still stalled", int'(stackReq), 1);
    stackAck = 1;
    cyc(0, 0, 0, 0, 0, 0);
    chk("R6 high byte after ack", int'(stackHi), 1);
    chk("R5 code held", int'(vecSel), 2);
    repeat (4) cyc(0, 0, 0, 0, 0, 0);
    chk("R9 pending kept after entry", int'(pendOut), 4'b1010);
    chk("R8 gie off after entry", int'(gieOut), 0);

    // R10 reti beats software write of 0
    cyc(0, 0, 0, 1, 1, 0);
    chk("R10 reti over write", int'(gieOut), 1);

    // R12 winner re-requested at start edge
    cyc(4'b1000, 0, 1, 0, 0, 0);
    chk("R5 wake code", int'(vecSel), 3);
    chk("R12 winner stays pending", int'(pendOut), 4'b1010);
    repeat (4) cyc(0, 0, 0, 0, 0, 0);
    chk("R7 done reached", int'(entryDone), 1);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R10 entry clear beats reti", int'(gieOut), 0);

    // R11 software clear
    cyc(4'b0010, 4'b0010, 0, 0, 0, 0);
    chk("R11 request beats clear", int'(pendOut), 4'b1010);
    cyc(0, 4'b1010, 0, 0, 0, 0);
    chk("R11 clear", int'(pendOut), 0);

    // R3 write of 0
    cyc(0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R3 write clears gie", int'(gieOut), 0);
    repeat (3) cyc(0, 0, 0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule